// File: doc/BRIEF.md
# Tagged-Word Packing Bridge (48-bit to 32-bit)

This block lets a processor whose memory words are 48 bits wide keep its backing store in an ordinary 32-bit host memory. Each processor word carries a 32-bit data field, an 8-bit tag and 8 ECC bits. The host memory is divided into blocks of 24 bytes. Each block stores four consecutive processor words. Two host words hold the tag/ECC halfwords and four host words hold the data fields, with the middle two data fields swapped.

The processor side uses a request/acknowledge handshake. It carries a word address, a direction and a 48-bit write value. The block serves memory writes, uncacheable reads and cacheable read misses. It turns each request into exactly two single-beat host transactions and answers with a one-cycle acknowledge. The acknowledge carries either the assembled word or an error flag. The base of the host region is an input that the surrounding system holds steady.

Top module: `pack48_bridge`

## Requirements
- R1: A processor word is laid out as ECC in bits 47:40, tag in bits 39:32 and data in bits 31:0. The block of word address A starts at host byte address regionBase + (A >> 2) * 24. The word's index within its block is A[1:0].
- R2: The data field of index 0, 1, 2, 3 sits at block byte offset 8, 16, 12, 20 respectively.
- R3: The tag/ECC halfword {ECC, tag} of index 0 or 1 sits in the host word at block offset 0, and that of index 2 or 3 sits in the host word at block offset 4. An even index uses bits 15:0 and an odd index uses bits 31:16.
- R4: A write issues two host writes in this order. The first goes to the tag/ECC word with write data {half, half} and byte enables 4'b0011 for an even index or 4'b1100 for an odd index, so the neighbour's halfword is preserved. The second goes to the data word with byte enables 4'b1111.
- R5: A read issues two host reads, tag/ECC word first and then the data word. The assembled 48-bit word is returned with a reqAck pulse lasting exactly one cycle.
- R6: Only one request is in flight at a time. reqAck rises only after both host beats of that request have completed, and no host beat is issued while the block is idle.
- R7: A host error on either beat ends the request with rspErr = 1 and rspData = 0. An error on the first beat suppresses the second beat.
- R8: While hostValid is high and hostReady is low, hostValid, hostWrite and hostAddr hold their values.
- R9: During reset hostValid and reqAck are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regionBase | input | 32 | Host byte address of the backing-store region |
| reqValid | input | 1 | Processor request, held until reqAck |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Processor word address |
| reqWdata | input | 48 | Word to write |
| reqAck | output | 1 | One-cycle completion pulse |
| rspData | output | 48 | Read word, valid with reqAck |
| rspErr | output | 1 | Host error flag, valid with reqAck |
| hostValid | output | 1 | Host beat request |
| hostWrite | output | 1 | Host beat direction |
| hostAddr | output | 32 | Host byte address |
| hostBe | output | 4 | Host byte enables |
| hostWdata | output | 32 | Host write data |
| hostReady | input | 1 | Host beat completes this cycle |
| hostRdata | input | 32 | Host read data |
| hostErr | input | 1 | Host beat failed (with hostReady) |

## Verification
The bench writes two neighbouring words that share a tag/ECC word and checks the shared host word. Byte enables that are too wide would overwrite the neighbour's halfword, and a lane placed wrongly would swap the two tags. Words at index 1 and 2 catch a data layout that is left unswapped, because their data would appear at each other's offset. Errors are injected on the first beat and then on the second. A design that issued the second beat anyway, or returned the half-assembled word, would show an extra beat or non-zero data. Host wait states check that a stretched beat still yields exactly two beats and the correct word.

// File: rtl/pack48_pkg.sv
package pack48_pkg;

  localparam int WORD_W   = 48;
  localparam int DATA_W   = 32;
  localparam int HALF_W   = WORD_W - DATA_W;
  localparam int HBYTES   = DATA_W / 8;
  localparam int BLK_WORDS = 6;
  localparam int BLK_BYTES = BLK_WORDS * HBYTES;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TAG  = 2'd1,
    ST_DATA = 2'd2,
    ST_DONE = 2'd3
  } bridgeState_t;

  typedef struct packed {
    logic latchReq;  // capture address and write value
    logic selData;   // current beat targets the data word
    logic capHalf;   // store tag/ECC lane of read data
    logic capData;   // store data field of read data
    logic clrRsp;    // host error: zero the response
  } dpStrobe_t;

endpackage

// File: rtl/pack48_ctrl.sv
module pack48_ctrl
  import pack48_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqWrite,
  input  logic      hostReady,
  input  logic      hostErr,
  output logic      hostValid,
  output logic      hostWrite,
  output logic      reqAck,
  output logic      rspErr,
  output dpStrobe_t strobe
);

  bridgeState_t stateQ;
  logic writeQ;
  logic errQ;
  logic beatDone;

  assign hostValid = (stateQ == ST_TAG) || (stateQ == ST_DATA);
  assign hostWrite = writeQ;
  assign reqAck    = (stateQ == ST_DONE);
  assign rspErr    = errQ;
  assign beatDone  = hostValid && hostReady;

  always_comb begin
    strobe          = '0;
    strobe.latchReq = (stateQ == ST_IDLE) && reqValid;
    strobe.selData  = (stateQ == ST_DATA);
    strobe.capHalf  = (stateQ == ST_TAG)  && beatDone && !hostErr && !writeQ;
    strobe.capData  = (stateQ == ST_DATA) && beatDone && !hostErr && !writeQ;
    strobe.clrRsp   = beatDone && hostErr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      writeQ <= 1'b0;
      errQ   <= 1'b0;
    end else begin
      unique case (stateQ)
        ST_IDLE: if (reqValid) begin
          writeQ <= reqWrite;
          errQ   <= 1'b0;
          stateQ <= ST_TAG;
        end
        ST_TAG: if (hostReady) begin
          if (hostErr) begin
            errQ   <= 1'b1;
            stateQ <= ST_DONE;
          end else begin
            stateQ <= ST_DATA;
          end
        end
        ST_DATA: if (hostReady) begin
          errQ   <= hostErr;
          stateQ <= ST_DONE;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |=> !reqAck);                                         // R5
  AST_ACK_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |-> $past(hostValid && hostReady));                   // R6
  AST_BEAT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (hostValid && !hostReady) |=> (hostValid && $stable(hostWrite))); // R8
  AST_FIRST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_TAG && hostReady && hostErr) |=> !hostValid);  // R7

endmodule

// File: rtl/pack48_dpath.sv
module pack48_dpath
  import pack48_pkg::*;
#(
  parameter int AW  = 16,
  parameter int HAW = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              beatActive,
  input  logic              hostReady,
  input  logic [HAW-1:0]    regionBase,
  input  logic [AW-1:0]     reqAddr,
  input  logic [WORD_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] hostRdata,
  output logic [HAW-1:0]    hostAddr,
  output logic [HBYTES-1:0] hostBe,
  output logic [DATA_W-1:0] hostWdata,
  output logic [WORD_W-1:0] rspData
);

  localparam int IDX_W = 2;

  logic [AW-1:0]     addrQ;
  logic [WORD_W-1:0] wdataQ;
  logic [IDX_W-1:0]  idx;
  logic [HAW-1:0]    blockBase;
  logic [HAW-1:0]    tagOff;
  logic [HAW-1:0]    dataOff;
  logic [HALF_W-1:0] halfOut;

  assign idx       = addrQ[IDX_W-1:0];
  assign halfOut   = wdataQ[WORD_W-1:DATA_W];
  assign blockBase = regionBase + HAW'(addrQ[AW-1:IDX_W]) * HAW'(BLK_BYTES);
  assign tagOff    = idx[1] ? HAW'(HBYTES) : '0;
  // data slots follow the tag words; index bits swapped give the slot order
  assign dataOff   = HAW'(2 * HBYTES) + HAW'({idx[0], idx[1], 2'b00});
  assign hostAddr  = blockBase + (strobe.selData ? dataOff : tagOff);
  assign hostWdata = strobe.selData ? wdataQ[DATA_W-1:0] : {halfOut, halfOut};
  assign hostBe    = strobe.selData ? '1 : (idx[0] ? 4'b1100 : 4'b0011);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      wdataQ  <= '0;
      rspData <= '0;
    end else begin
      if (strobe.latchReq) begin
        addrQ   <= reqAddr;
        wdataQ  <= reqWdata;
        rspData <= '0;
      end
      if (strobe.capHalf)
        rspData[WORD_W-1:DATA_W] <= idx[0] ? hostRdata[DATA_W-1:HALF_W]
                                           : hostRdata[HALF_W-1:0];
      if (strobe.capData)
        rspData[DATA_W-1:0] <= hostRdata;
      if (strobe.clrRsp)
        rspData <= '0;
    end
  end

  AST_HALF_ENABLES: assert property (@(posedge clk) disable iff (!rstN)
    (beatActive && !strobe.selData) |-> (hostBe == 4'b0011 || hostBe == 4'b1100)); // R4
  AST_DATA_FULL_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (beatActive && strobe.selData) |-> (hostBe == 4'b1111));     // R4
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (beatActive && !hostReady) |=> $stable(hostAddr));           // R8

endmodule

// File: rtl/pack48_bridge.sv
module pack48_bridge
  import pack48_pkg::*;
#(
  parameter int AW  = 16,
  parameter int HAW = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [HAW-1:0]    regionBase,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [AW-1:0]     reqAddr,
  input  logic [WORD_W-1:0] reqWdata,
  output logic              reqAck,
  output logic [WORD_W-1:0] rspData,
  output logic              rspErr,
  output logic              hostValid,
  output logic              hostWrite,
  output logic [HAW-1:0]    hostAddr,
  output logic [HBYTES-1:0] hostBe,
  output logic [DATA_W-1:0] hostWdata,
  input  logic              hostReady,
  input  logic [DATA_W-1:0] hostRdata,
  input  logic              hostErr
);

  dpStrobe_t strobe;

  pack48_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .hostReady (hostReady),
    .hostErr   (hostErr),
    .hostValid (hostValid),
    .hostWrite (hostWrite),
    .reqAck    (reqAck),
    .rspErr    (rspErr),
    .strobe    (strobe)
  );

  pack48_dpath #(.AW(AW), .HAW(HAW)) uDpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .beatActive (hostValid),
    .hostReady  (hostReady),
    .regionBase (regionBase),
    .reqAddr    (reqAddr),
    .reqWdata   (reqWdata),
    .hostRdata  (hostRdata),
    .hostAddr   (hostAddr),
    .hostBe     (hostBe),
    .hostWdata  (hostWdata),
    .rspData    (rspData)
  );

  AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (reqAck && rspErr) |-> (rspData == '0));                     // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (hostValid && reqAck) |-> 1'b0);                             // R6

endmodule

// File: tb/sim_pack48_bridge.sv
module sim_pack48_bridge;

  localparam int CLK_NS = 20;
  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam int NVEC = 6;
  localparam logic [63:0] VEC [NVEC] = '{
    {16'd0, 48'h1122_AAAA_0000},
    {16'd1, 48'h3344_BBBB_1111},
    {16'd2, 48'h5566_CCCC_2222},
    {16'd3, 48'h7788_DDDD_3333},
    {16'd5, 48'h99AA_EEEE_5555},
    {16'd6, 48'hBBCC_FFFF_6666}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [47:0] reqWdata = '0;
  logic        reqAck, rspErr, hostValid, hostWrite;
  logic [47:0] rspData;
  logic [31:0] hostAddr, hostWdata;
  logic [3:0]  hostBe;
  logic        hostReady = 1'b0, hostErr = 1'b0;
  logic [31:0] hostRdata = '0;

  int errors = 0, checks = 0;
  logic [31:0] mem [64];
  int logN = 0, hostWait = 0, waitLeft = 0, errBeat = -1;
  logic [31:0] logAddr [4];
  logic [3:0]  logBe [4];
  logic [31:0] logData [4];
  logic        logWr [4];

  always #(CLK_NS/2) clk = ~clk;

  pack48_bridge u0 (
    .clk(clk), .rstN(rstN), .regionBase(BASE),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqAck(reqAck), .rspData(rspData), .rspErr(rspErr),
    .hostValid(hostValid), .hostWrite(hostWrite), .hostAddr(hostAddr), .hostBe(hostBe),
    .hostWdata(hostWdata), .hostReady(hostReady), .hostRdata(hostRdata), .hostErr(hostErr)
  );

  // host memory model: answers away from the rising edge
  always @(negedge clk) begin
    if (hostValid && waitLeft > 0) begin
      hostReady = 1'b0; hostErr = 1'b0; waitLeft = waitLeft - 1;
    end else if (hostValid) begin
      int w;
      w = int'((hostAddr - BASE) >> 2) % 64;
      hostReady = 1'b1;
      hostErr = (errBeat == logN);
      if (logN < 4) begin
        logAddr[logN] = hostAddr; logBe[logN] = hostBe;
        logData[logN] = hostWdata; logWr[logN] = hostWrite;
      end
      logN = logN + 1;
      if (hostWrite && !hostErr)
        for (int b = 0; b < 4; b++)
          if (hostBe[b]) mem[w][b*8 +: 8] = hostWdata[b*8 +: 8];
      hostRdata = mem[w];
      waitLeft = hostWait;
    end else begin
      hostReady = 1'b0; hostErr = 1'b0; waitLeft = hostWait;
    end
  end

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] expTag(input logic [15:0] a);
    return BASE + 32'(a >> 2) * 24 + (a[1] ? 32'd4 : 32'd0);
  endfunction

  function automatic logic [31:0] expData(input logic [15:0] a);
    logic [31:0] off;
    case (a[1:0])
      2'd0: off = 8;  2'd1: off = 16;
      2'd2: off = 12; default: off = 20;
    endcase
    return BASE + 32'(a >> 2) * 24 + off;
  endfunction

  task automatic doReq(input logic wr, input logic [15:0] a, input logic [47:0] wd,
                       output logic [47:0] rd, output logic er, output int nb);
    @(negedge clk);
    logN = 0;
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = wd;
    forever begin
      @(negedge clk);
      if (reqAck) break;
    end
    rd = rspData; er = rspErr; nb = logN;
    reqValid = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [47:0] rd;
    logic er;
    int nb;
    for (int i = 0; i < 64; i++) mem[i] = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    chk("R9 hostValid in reset", 64'(hostValid), 64'd0);
    chk("R9 reqAck in reset", 64'(reqAck), 64'd0);
    rstN = 1'b1;

    // table of writes: beat order, addresses, enables and data
    for (int i = 0; i < NVEC; i++) begin
      logic [15:0] a;
      logic [47:0] v;
      a = VEC[i][63:48]; v = VEC[i][47:0];
      doReq(1'b1, a, v, rd, er, nb);
      chk("R4 write beat count", 64'(nb), 64'd2);
      chk("R3 tag word addr", 64'(logAddr[0]), 64'(expTag(a)));
      chk("R4 tag enables", 64'(logBe[0]), a[0] ? 64'hC : 64'h3);
      chk("R4 tag write data", 64'(logData[0]), 64'({v[47:32], v[47:32]}));
      chk("R2 data word addr", 64'(logAddr[1]), 64'(expData(a)));
      chk("R4 data enables/data", {28'd0, logBe[1], logData[1]}, {28'd0, 4'hF, v[31:0]});
      chk("R4 both writes", 64'({logWr[0], logWr[1]}), 64'd3);
    end

    // memory image built from R1..R3
    chk("R3 block0 tag word0", 64'(mem[0]), 64'h3344_1122);
    chk("R3 block0 tag word1", 64'(mem[1]), 64'h7788_5566);
    chk("R2 data idx0 @8",  64'(mem[2]), 64'hAAAA_0000);
    chk("R2 data idx2 @12", 64'(mem[3]), 64'hCCCC_2222);
    chk("R2 data idx1 @16", 64'(mem[4]), 64'hBBBB_1111);
    chk("R2 data idx3 @20", 64'(mem[5]), 64'hDDDD_3333);
    chk("R1 block1 tag keeps neighbour", 64'(mem[6]), 64'h99AA_BEEF);
    chk("R1 block1 tag word1 keeps neighbour", 64'(mem[7]), 64'hDEAD_BBCC);
    chk("R1 block1 data idx1", 64'(mem[10]), 64'hEEEE_5555);
    chk("R1 block1 data idx2", 64'(mem[9]), 64'hFFFF_6666);

    // read back every word
    for (int i = 0; i < NVEC; i++) begin
      doReq(1'b0, VEC[i][63:48], 48'd0, rd, er, nb);
      chk("R5 read word", 64'(rd), 64'(VEC[i][47:0]));
      chk("R5 read ok, two beats", {31'd0, er, 32'(nb)}, 64'd2);
      chk("R5 tag beat first", 64'(logAddr[0]), 64'(expTag(VEC[i][63:48])));
    end

    // ack is one cycle wide and idle is quiet
    @(negedge clk);
    chk("R5 ack single cycle", 64'(reqAck), 64'd0);
    logN = 0;
    repeat (5) @(negedge clk);
    chk("R6 no beats while idle", 64'(logN), 64'd0);

    // host wait states
    hostWait = 3;
    doReq(1'b0, 16'd2, 48'd0, rd, er, nb);
    chk("R8 read under wait states", 64'(rd), 64'h5566_CCCC_2222);
    chk("R8 beats under wait states", 64'(nb), 64'd2);
    hostWait = 0;

    // error on first beat
    errBeat = 0;
    doReq(1'b0, 16'd1, 48'd0, rd, er, nb);
    chk("R7 err beat0 flag", 64'(er), 64'd1);
    chk("R7 err beat0 data", 64'(rd), 64'd0);
    chk("R7 err beat0 no second beat", 64'(nb), 64'd1);

    // error on second beat
    errBeat = 1;
    doReq(1'b0, 16'd3, 48'd0, rd, er, nb);
    chk("R7 err beat1 flag", 64'(er), 64'd1);
    chk("R7 err beat1 data", 64'(rd), 64'd0);
    chk("R7 err beat1 beats", 64'(nb), 64'd2);

    // failed write leaves the stored word untouched
    errBeat = 0;
    doReq(1'b1, 16'd0, 48'hFFFF_1234_5678, rd, er, nb);
    chk("R7 err write flag", 64'(er), 64'd1);
    errBeat = -1;
    doReq(1'b0, 16'd0, 48'd0, rd, er, nb);
    chk("R7 word after failed write", 64'(rd), 64'h1122_AAAA_0000);
    chk("R6 next request served", 64'(er), 64'd0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule